// File: doc/BRIEF.md
# AES3 Channel-Status Bit Sequencer

This block supplies the per-subframe side bits of an AES3 transmitter: channel status (C), user data (U) and validity (V). It also tracks the position of each subframe inside the 192-frame channel-status block. It runs on a master clock at 256 times the audio sample rate. The word-rate clock (`lrclk_i`) is synchronous to that master clock. Each change of `lrclk_i` opens a new subframe: a low level is the left subframe, which opens a frame, and a high level is the right subframe. On each subframe the block presents the three bits, the frame index, the channel and a one-cycle strobe. A downstream encoder then latches these into the outgoing subframe.

The C bit has two sources, chosen by a mode pin. In pin mode, a consumer-format status word is built from four control pins, and frame n carries bit n of that word. In serial mode, the C bit is whatever the shared copy/serial pin holds at the boundary.

The block-start marker has two directions. As an output, it flags the first subframe of each block. As an input, a pulse that lasts long enough forces the next frame to be frame 0 of a new block.

Top module: `aes_cs_seq`

## Requirements
- R1: While `rst` is high on a clock edge, every output is 0 after that edge.
- R2: The cycle after a clock edge that sees `lrclk_i` differ from its value on the previous edge, `sub_stb_o` is 1 for one cycle and `chan_o` equals the new `lrclk_i` level (0 = left, 1 = right). The other outputs change only on that same edge.
- R3: `v_bit_o` and `u_bit_o` take the values of `valid_pin_i` and `user_pin_i` sampled at the subframe boundary edge, once for each subframe.
- R4: `frame_o` advances by one at each left boundary and wraps from 191 to 0. Both subframes of a frame share one index. The first left subframe after reset is frame 0.
- R5: With `cmode_i` = 0, `c_bit_o` is bit `frame_o` of a 192-bit word. In that word, bit 1 = `nonaudio_i`, bit 2 = `copy_c_i`, bits 3..5 = 1,0,0 when `emph_n_i` = 0 and 0,0,0 when `emph_n_i` = 1, and bit 15 = `orig_i`. All other bits are 0, including bit 0 (consumer format).
- R6: With `cmode_i` = 1, `c_bit_o` equals `copy_c_i` sampled at the boundary edge.
- R7: With `blk_dir_i` = 1, `blk_out_o` is 1 exactly during the left subframe of frame 0. With `blk_dir_i` = 0 it stays 0.
- R8: With `blk_dir_i` = 0, if `blk_in_i` is high on at least 3 consecutive edges after a two-flop synchronizer, the next left subframe is frame 0. A shorter pulse, or any pulse while `blk_dir_i` = 1, leaves the frame sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256x sample rate |
| rst | input | 1 | Synchronous active-high reset |
| lrclk_i | input | 1 | Word-rate clock; low = left subframe |
| valid_pin_i | input | 1 | Validity bit source |
| user_pin_i | input | 1 | User data bit source |
| cmode_i | input | 1 | C source: 0 pin-built word, 1 serial pin |
| copy_c_i | input | 1 | Copy-permit bit (pin mode) or serial C bit |
| orig_i | input | 1 | Generation status bit (word bit 15) |
| emph_n_i | input | 1 | Low selects 50/15 us emphasis code |
| nonaudio_i | input | 1 | Non-audio flag (word bit 1) |
| blk_dir_i | input | 1 | 1 = block marker is output, 0 = input |
| blk_in_i | input | 1 | Block resync pulse input |
| blk_out_o | output | 1 | Block-start marker output |
| sub_stb_o | output | 1 | One-cycle subframe strobe |
| chan_o | output | 1 | 0 left, 1 right |
| c_bit_o | output | 1 | Channel-status bit of this subframe |
| u_bit_o | output | 1 | User bit of this subframe |
| v_bit_o | output | 1 | Validity bit of this subframe |
| frame_o | output | 8 | Frame index within the block, 0..191 |

## Verification
Every subframe result lands one cycle after the edge on which the `lrclk_i` change is seen. A resync pulse needs two synchronizer cycles plus three width cycles before it arms, and it takes effect only at the following left boundary. The bench keeps a behavioural model that is advanced on each rising edge from the inputs stable at that edge. It compares every output against that model at the falling edge, so all register latencies are accounted for. Directed checks at the left boundaries after short, valid and disabled resync pulses confirm R8 directly.

// File: rtl/aes_cs_pkg.sv
package aes_cs_pkg;

    localparam int FRAMES_PER_BLOCK = 192;
    localparam int FIDX_W           = $clog2(FRAMES_PER_BLOCK);
    localparam int LAST_FRAME       = FRAMES_PER_BLOCK - 1;

    localparam int BIT_NONAUDIO = 1;
    localparam int BIT_COPY     = 2;
    localparam int BIT_EMPH_LO  = 3;
    localparam int BIT_ORIG     = 15;

    typedef logic [FIDX_W-1:0] fidx_t;

    typedef enum logic {
        CSRC_PINS   = 1'b0,
        CSRC_SERIAL = 1'b1
    } csrc_e;

    typedef struct packed {
        logic nonaudio;
        logic copy_ok;
        logic orig;
        logic emph_off;
    } cs_pins_t;

    typedef struct packed {
        logic  stb;
        logic  chan;
        logic  c;
        logic  u;
        logic  v;
        logic  blk;
        fidx_t frame;
    } sub_bits_t;

    function automatic logic cs_word_bit(fidx_t idx, cs_pins_t p);
        logic b;
        case (int'(idx))
            BIT_NONAUDIO: b = p.nonaudio;
            BIT_COPY:     b = p.copy_ok;
            BIT_EMPH_LO:  b = ~p.emph_off;
            BIT_ORIG:     b = p.orig;
            default:      b = 1'b0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/aes_cs_resync.sv
module aes_cs_resync #(
    parameter int MIN_W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic strobe_i,
    output logic hit_o
);
    localparam int CW = $clog2(MIN_W + 1);

    logic          s1, s2;
    logic [CW-1:0] wcnt;

    assign hit_o = en && s2 && (wcnt == CW'(MIN_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            wcnt <= '0;
        end else begin
            s1 <= strobe_i;
            s2 <= s1;
            if (!en || !s2)
                wcnt <= '0;
            else if (wcnt != CW'(MIN_W))
                wcnt <= wcnt + 1'b1;
        end
    end

    assert_resync_oneshot_R8: assert property (@(posedge clk) disable iff (rst)
        hit_o |=> !hit_o);

    assert_resync_needs_high_R8: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> $past(s2));

endmodule

// File: rtl/aes_cs_framer.sv
module aes_cs_framer
    import aes_cs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  lrclk_i,
    input  logic  resync_i,
    output logic  bnd_o,
    output logic  left_o,
    output fidx_t fidx_o
);
    logic  lr_d;
    logic  pend;
    fidx_t cnt;
    fidx_t nxt;

    assign bnd_o  = lrclk_i != lr_d;
    assign left_o = bnd_o && !lrclk_i;
    assign nxt    = (pend || cnt == fidx_t'(LAST_FRAME)) ? '0 : cnt + 1'b1;
    assign fidx_o = left_o ? nxt : cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lr_d <= 1'b0;
            pend <= 1'b0;
            cnt  <= fidx_t'(LAST_FRAME);
        end else begin
            lr_d <= lrclk_i;
            if (left_o) begin
                cnt  <= nxt;
                pend <= resync_i;
            end else if (resync_i) begin
                pend <= 1'b1;
            end
        end
    end

    assert_frame_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !left_o |=> $stable(cnt));

    assert_frame_range_R4: assert property (@(posedge clk) disable iff (rst)
        cnt <= fidx_t'(LAST_FRAME));

    assert_resync_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (left_o && pend) |=> cnt == '0);

endmodule

// File: rtl/aes_cs_seq.sv
module aes_cs_seq
    import aes_cs_pkg::*;
#(
    parameter int RESYNC_MIN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lrclk_i,
    input  logic              valid_pin_i,
    input  logic              user_pin_i,
    input  logic              cmode_i,
    input  logic              copy_c_i,
    input  logic              orig_i,
    input  logic              emph_n_i,
    input  logic              nonaudio_i,
    input  logic              blk_dir_i,
    input  logic              blk_in_i,
    output logic              blk_out_o,
    output logic              sub_stb_o,
    output logic              chan_o,
    output logic              c_bit_o,
    output logic              u_bit_o,
    output logic              v_bit_o,
    output logic [FIDX_W-1:0] frame_o
);
    logic      hit, bnd, left;
    fidx_t     fidx;
    cs_pins_t  pins;
    csrc_e     csrc;
    sub_bits_t q;

    assign pins = '{nonaudio: nonaudio_i, copy_ok: copy_c_i,
                    orig: orig_i, emph_off: emph_n_i};
    assign csrc = csrc_e'(cmode_i);

    aes_cs_resync #(.MIN_W(RESYNC_MIN)) u_resync (
        .clk      (clk),
        .rst      (rst),
        .en       (!blk_dir_i),
        .strobe_i (blk_in_i),
        .hit_o    (hit)
    );

    aes_cs_framer u_framer (
        .clk      (clk),
        .rst      (rst),
        .lrclk_i  (lrclk_i),
        .resync_i (hit),
        .bnd_o    (bnd),
        .left_o   (left),
        .fidx_o   (fidx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.stb <= bnd;
            if (bnd) begin
                q.chan  <= lrclk_i;
                q.v     <= valid_pin_i;
                q.u     <= user_pin_i;
                q.c     <= (csrc == CSRC_SERIAL) ? copy_c_i : cs_word_bit(fidx, pins);
                q.frame <= fidx;
                q.blk   <= blk_dir_i && left && (fidx == '0);
            end
        end
    end

    assign sub_stb_o = q.stb;
    assign chan_o    = q.chan;
    assign c_bit_o   = q.c;
    assign u_bit_o   = q.u;
    assign v_bit_o   = q.v;
    assign frame_o   = q.frame;
    assign blk_out_o = q.blk;

    assert_stb_chan_R2: assert property (@(posedge clk) disable iff (rst)
        sub_stb_o |-> chan_o == $past(lrclk_i));

    assert_vu_sample_R3: assert property (@(posedge clk) disable iff (rst)
        sub_stb_o |-> (v_bit_o == $past(valid_pin_i)) && (u_bit_o == $past(user_pin_i)));

    assert_serial_c_R6: assert property (@(posedge clk) disable iff (rst)
        (sub_stb_o && $past(cmode_i)) |-> c_bit_o == $past(copy_c_i));

    assert_blk_first_R7: assert property (@(posedge clk) disable iff (rst)
        blk_out_o |-> (frame_o == '0) && !chan_o);

endmodule

// File: tb/sim_aes_cs_seq.sv
module sim_aes_cs_seq;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lrclk = 1'b0, vpin = 1'b0, upin = 1'b0, cmode = 1'b0, copyc = 1'b0;
    logic orig = 1'b0, emphn = 1'b1, nonaud = 1'b0, bdir = 1'b1, bin = 1'b0;
    logic blk_out, stb, chan, cb, ub, vb;
    logic [7:0] frame;

    always #10 clk = ~clk;

    aes_cs_seq u0 (
        .clk(clk), .rst(rst), .lrclk_i(lrclk), .valid_pin_i(vpin), .user_pin_i(upin),
        .cmode_i(cmode), .copy_c_i(copyc), .orig_i(orig), .emph_n_i(emphn),
        .nonaudio_i(nonaud), .blk_dir_i(bdir), .blk_in_i(bin), .blk_out_o(blk_out),
        .sub_stb_o(stb), .chan_o(chan), .c_bit_o(cb), .u_bit_o(ub), .v_bit_o(vb),
        .frame_o(frame)
    );

    int n_chk = 0, n_fail = 0, cycles = 0;
    bit cmp_on = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
        end
    endtask

    // reference model state
    int m_lr, m_cnt, m_pend, m_s1, m_s2, m_w;
    int e_stb, e_chan, e_c, e_u, e_v, e_blk, e_frame;

    function automatic int word_bit(int n);
        if (n == 1) return nonaud;
        if (n == 2) return copyc;
        if (n == 3) return emphn ? 0 : 1;
        if (n == 15) return orig;
        return 0;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_lr = 0; m_cnt = 191; m_pend = 0; m_s1 = 0; m_s2 = 0; m_w = 0;
            e_stb = 0; e_chan = 0; e_c = 0; e_u = 0; e_v = 0; e_blk = 0; e_frame = 0;
        end else begin
            int hit;
            int edge_seen;
            int idx;
            hit = (!bdir && m_s2 == 1 && m_w == 2) ? 1 : 0;
            if (bdir || !m_s2) m_w = 0; else if (m_w < 3) m_w = m_w + 1;
            m_s2 = m_s1; m_s1 = bin;
            edge_seen = (lrclk != m_lr);
            e_stb = edge_seen;
            idx = m_cnt;
            if (edge_seen && !lrclk) begin
                idx = m_pend ? 0 : (m_cnt + 1) % 192;
                m_cnt = idx;
                m_pend = hit;
            end else if (hit) m_pend = 1;
            if (edge_seen) begin
                e_chan = lrclk; e_v = vpin; e_u = upin; e_frame = idx;
                e_c = cmode ? copyc : word_bit(idx);
                e_blk = (bdir && !lrclk && idx == 0) ? 1 : 0;
            end
            m_lr = lrclk;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(stb == e_stb[0], "R2 strobe", stb, e_stb);
            chk(chan == e_chan[0], "R2 chan", chan, e_chan);
            chk(vb == e_v[0], "R3 v", vb, e_v);
            chk(ub == e_u[0], "R3 u", ub, e_u);
            chk(int'(frame) == e_frame, "R4 frame", frame, e_frame);
            chk(cb == e_c[0], cmode ? "R6 c serial" : "R5 c word", cb, e_c);
            chk(blk_out == e_blk[0], "R7 blk", blk_out, e_blk);
        end
    end

    // word clock and V/U pattern
    int ph = 0;
    logic [15:0] lfsr = 16'hACE1;
    always @(negedge clk) begin
        if (rst) begin
            ph = 0; lrclk <= 1'b0;
        end else begin
            ph++;
            if (ph == 128) begin ph = 0; lrclk <= ~lrclk; end
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        vpin <= lfsr[3];
        upin <= lfsr[7];
        if (cmode) copyc <= lfsr[11];
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input int w);
        @(negedge clk); bin = 1'b1;
        wait_cyc(w);
        bin = 1'b0;
    endtask

    task automatic next_left;
        @(negedge clk);
        while (!(stb && !chan)) @(negedge clk);
    endtask

    int prev_f;
    int blk_seen = 0;
    always @(negedge clk) if (!rst && blk_out && stb) blk_seen++;

    initial begin
        emphn = 1'b0; nonaud = 1'b1; copyc = 1'b1; orig = 1'b1;
        wait_cyc(4);
        chk({blk_out, stb, chan, cb, ub, vb, frame} == '0, "R1 reset", int'(frame), 0);
        rst = 1'b0;
        cmp_on = 1;
        wait_cyc(60 * 256);
        emphn = 1'b1; copyc = 1'b0; orig = 1'b0; nonaud = 1'b0;
        wait_cyc(140 * 256);
        chk(blk_seen >= 2, "R7 block marks", blk_seen, 2);
        cmode = 1'b1;
        wait_cyc(16 * 256);
        cmode = 1'b0; copyc = 1'b1; emphn = 1'b0;
        bdir = 1'b0;
        wait_cyc(6 * 256 + 40);
        pulse(2);
        next_left; prev_f = frame;
        next_left;
        chk(int'(frame) == (prev_f + 1) % 192, "R8 short pulse ignored", frame, (prev_f + 1) % 192);
        wait_cyc(60);
        pulse(3);
        next_left;
        chk(frame == 8'd0, "R8 resync to frame 0", frame, 0);
        chk(blk_out == 1'b0, "R7 no mark when input", blk_out, 0);
        wait_cyc(3 * 256);
        bdir = 1'b1;
        wait_cyc(60);
        pulse(6);
        next_left; prev_f = frame;
        next_left;
        chk(int'(frame) == (prev_f + 1) % 192, "R8 pulse ignored as output", frame, (prev_f + 1) % 192);
        wait_cyc(2 * 256);
        cmp_on = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait_cyc(190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule